// File: doc/BRIEF.md
# A/D Conversion Sequencer with Control and Result Registers

This block sits between a CPU-style register bus and the analog front end of an 8-bit successive-approximation converter. Software sees two registers. The first is a control/status register that holds the converter enable, the clock choice, a 2-bit channel number and a read-only done flag. The second is a result register. The block drives the channel number, the enable and the clock choice to the front end. It presents a trial level to the DAC and takes back a single comparator bit. From that bit it builds the result, most significant bit first.

A conversion starts on any bus access to either register: a read strobe or a write strobe. The done flag drops on the same access and rises again once a fresh result is in the result register. The converter can run either from the bus clock or from a separate, unrelated clock. In both cases the finished code reaches the result register through a toggle handshake, so the code is always captured in the bus clock domain. When the converter is disabled, no access starts a conversion and the flag stays low.

`rdata` always shows the register picked by `sel`. Only an `rd` or `wr` strobe counts as an access, so a bench or a debugger can observe the registers without disturbing them.

Top module: `adc_sar_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, `adc_en` and `clk_sel` are 0, and `chan` is 0.
- R2: The control register reads as {done flag (bit 7), clock select (bit 6), enable (bit 5), 0, 0, 0, channel (bits 1:0)}. Bits 4:2 read 0 whatever was written, and a write never sets bit 7, so writing 0xFF reads back 0x63.
- R3: A conversion ends with the result register (`sel`=1) holding the largest code N such that the input is at or above level N. Trials run MSB first, and a trial bit is kept when `cmp_in`=1. `cmp_in`=1 means the input is at or above `dac_code`.
- R4: The done flag rises only after a conversion has finished and its code has been written into the result register.
- R5: A read strobe on the result register returns the current code, clears the done flag on the next cycle, and starts a new conversion.
- R6: A read or write strobe on the control register clears the done flag on the next cycle and starts a new conversion while enable is 1.
- R7: Each new result replaces the previous one, whether or not the done flag was read. A restart during a running conversion yields the code for the input present after the restart.
- R8: While enable is 0, accesses start no conversion, the done flag stays 0, and the result register keeps its value.
- R9: `chan`, `adc_en` and `clk_sel` follow control bits 1:0, 5 and 6. With clock select at 1 the sequencer runs from `rc_clk`, and its code is still delivered correctly into the bus domain. The code is held stable until the bus side acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_clk | input | 1 | Separate converter clock |
| sel | input | 1 | Register select: 0 control, 1 result |
| rd | input | 1 | Read strobe (counts as an access) |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Selected register contents |
| chan | output | 2 | Analog channel select |
| adc_en | output | 1 | Converter enable to front end |
| clk_sel | output | 1 | 1 = converter on rc_clk, 0 = on clk |
| dac_code | output | 8 | Trial level presented to the DAC |
| cmp_in | input | 1 | Comparator: input at or above dac_code |

## Verification
The bench models the comparator as a plain compare of an input code against `dac_code`. A sequencer with a wrong bit order or a wrong keep rule would therefore return a code that differs from the input, including at 0x00, 0xFF, 0x80 and 0x7F. Three checks cover the done flag:
- The flag is checked to drop one cycle after each kind of access. A design that cleared it only on a result read would leave it high after a control write.
- The input is changed between conversions and in the middle of a conversion. A design that kept a stale or aborted result would show the old code.
- With enable off, accesses are checked to leave the flag and the result untouched.

Runs from the separate clock check that the handshake delivers the right code across the clock boundary.

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rc_clk,
  input  logic         sel,
  input  logic         rd,
  input  logic         wr,
  input  logic [7:0]   wdata,
  output logic [7:0]   rdata,
  output logic [1:0]   chan,
  output logic         adc_en,
  output logic         clk_sel,
  output logic [W-1:0] dac_code,
  input  logic         cmp_in
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic         ccf, csel, en;
  logic [1:0]   ch;
  logic [W-1:0] data_r;
  logic         st_tgl, dn_s1, dn_s2, ack_tgl;
  logic         acc, en_nx, cap;

  logic         cclk;
  logic         st_s1, st_s2, st_s3, ak_s1, ak_s2;
  logic         busy, smp, done_tgl, run_id, res_id;
  logic [CW-1:0] cnt;
  logic [W-1:0] sar, res_hold;
  logic         go, pending;

  assign acc     = rd | wr;
  assign en_nx   = (wr && !sel) ? wdata[5] : en;
  assign cap     = (dn_s2 ^ ack_tgl) && en && (res_id == st_tgl);
  assign rdata   = sel ? 8'(data_r) : {ccf, csel, en, 3'b000, ch};
  assign chan    = ch;
  assign adc_en  = en;
  assign clk_sel = csel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccf <= 1'b0; csel <= 1'b0; en <= 1'b0; ch <= 2'b00;
      data_r <= '0; st_tgl <= 1'b0;
      dn_s1 <= 1'b0; dn_s2 <= 1'b0; ack_tgl <= 1'b0;
    end else begin
      if (wr && !sel) begin
        csel <= wdata[6];
        en   <= wdata[5];
        ch   <= wdata[1:0];
      end
      if (acc && en_nx) st_tgl <= ~st_tgl;
      dn_s1   <= done_tgl;
      dn_s2   <= dn_s1;
      ack_tgl <= dn_s2;
      if (cap) data_r <= res_hold;
      if (acc) ccf <= 1'b0;
      else if (cap) ccf <= 1'b1;
    end
  end

  p_ccf_clr_r6: assert property (@(posedge clk) disable iff (!rst_n) acc |=> !ccf);
  p_off_r8:     assert property (@(posedge clk) disable iff (!rst_n) !en |-> !ccf);
  p_rise_r4:    assert property (@(posedge clk) disable iff (!rst_n) $rose(ccf) |-> !$past(acc));
  p_data_r7:    assert property (@(posedge clk) disable iff (!rst_n) !cap |=> $stable(data_r));

  assign cclk     = csel ? rc_clk : clk;
  assign go       = st_s2 ^ st_s3;
  assign pending  = done_tgl ^ ak_s2;
  assign dac_code = (busy && !smp) ? (sar | (W'(1) << cnt)) : '0;

  always_ff @(posedge cclk or negedge rst_n) begin
    if (!rst_n) begin
      st_s1 <= 1'b0; st_s2 <= 1'b0; st_s3 <= 1'b0;
      ak_s1 <= 1'b0; ak_s2 <= 1'b0;
      busy <= 1'b0; smp <= 1'b0; cnt <= '0; sar <= '0;
      res_hold <= '0; res_id <= 1'b0; run_id <= 1'b0; done_tgl <= 1'b0;
    end else begin
      st_s1 <= st_tgl;
      st_s2 <= st_s1;
      st_s3 <= st_s2;
      ak_s1 <= ack_tgl;
      ak_s2 <= ak_s1;
      if (go) begin
        busy   <= 1'b1;
        smp    <= 1'b1;
        sar    <= '0;
        cnt    <= CW'(W - 1);
        run_id <= st_s2;
      end else if (busy) begin
        if (smp) smp <= 1'b0;
        else begin
          if (cmp_in) sar[cnt] <= 1'b1;
          if (cnt == '0) begin
            if (!pending) begin
              res_hold <= sar | W'(cmp_in);
              res_id   <= run_id;
              done_tgl <= ~done_tgl;
              busy     <= 1'b0;
            end
          end else cnt <= cnt - 1'b1;
        end
      end
    end
  end

  p_hold_r9: assert property (@(posedge cclk) disable iff (!rst_n) pending |=> $stable(res_hold));
endmodule

// File: tb/sim_adc_sar_ctrl.sv
module sim_adc_sar_ctrl;
  logic clk = 1'b0, rc_clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0, rdata, dac_code, vin = '0;
  logic [1:0] chan;
  logic adc_en, clk_sel, cmp_in;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always #5 rc_clk = ~rc_clk;
  assign cmp_in = (vin >= dac_code);

  adc_sar_ctrl u0 (.clk(clk), .rst_n(rst_n), .rc_clk(rc_clk), .sel(sel), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .chan(chan), .adc_en(adc_en), .clk_sel(clk_sel),
    .dac_code(dac_code), .cmp_in(cmp_in));

  // [10] clock select, [9:8] channel, [7:0] input code
  localparam logic [10:0] VEC [6] = '{
    {1'b0, 2'd0, 8'h00}, {1'b0, 2'd1, 8'hFF}, {1'b0, 2'd2, 8'h80},
    {1'b0, 2'd3, 8'h7F}, {1'b1, 2'd1, 8'hA5}, {1'b1, 2'd2, 8'h3C}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(logic s, logic is_wr, logic [7:0] d);
    @(negedge clk);
    sel = s; wdata = d; wr = is_wr; rd = !is_wr;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic peek(logic s, output logic [7:0] v);
    sel = s; #0.5; v = rdata;
  endtask

  task automatic wait_ccf(string req);
    logic [7:0] v;
    bit seen = 1'b0;
    for (int i = 0; i < 600 && !seen; i++) begin
      @(negedge clk);
      peek(1'b0, v);
      seen = v[7];
    end
    chk(req, 8'(seen), 8'd1);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, ctl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(1'b0, v); chk("R1 ctl", v, 8'h00);
    peek(1'b1, v); chk("R1 data", v, 8'h00);
    chk("R1 outs", {5'b0, adc_en, clk_sel, 1'b0}, 8'h00);
    chk("R1 chan", 8'(chan), 8'h00);

    for (int i = 0; i < 6; i++) begin
      vin = VEC[i][7:0];
      ctl = {1'b0, VEC[i][10], 1'b1, 3'b000, VEC[i][9:8]};
      access(1'b0, 1'b1, ctl);
      wait_ccf("R4 flag");
      peek(1'b1, v); chk("R3 code", v, vin);
      peek(1'b0, v); chk("R2 ctl read", v, ctl | 8'h80);
      chk("R9 chan", 8'(chan), 8'(VEC[i][9:8]));
      chk("R9 en/csel", {6'b0, adc_en, clk_sel}, {6'b0, 1'b1, VEC[i][10]});
    end

    access(1'b0, 1'b1, 8'hFF);
    peek(1'b0, v); chk("R2 unused bits", v, 8'h63);
    wait_ccf("R9 rc flag");
    peek(1'b0, v); chk("R2 flag only", v, 8'hE3);
    peek(1'b1, v); chk("R9 rc code", v, 8'h3C);

    access(1'b0, 1'b1, 8'h21);
    wait_ccf("R6 setup");
    vin = 8'h5A;
    @(negedge clk);
    sel = 1'b1; rd = 1'b1; #0.5;
    chk("R5 read value", rdata, 8'h3C);
    @(negedge clk); rd = 1'b0;
    peek(1'b0, v); chk("R5 flag clear", 8'(v[7]), 8'd0);
    wait_ccf("R5 restart");
    peek(1'b1, v); chk("R5 new code", v, 8'h5A);

    vin = 8'hC3;
    access(1'b0, 1'b1, 8'h21);
    peek(1'b0, v); chk("R6 flag clear wr", 8'(v[7]), 8'd0);
    wait_ccf("R6 restart");
    peek(1'b1, v); chk("R6 code", v, 8'hC3);

    vin = 8'h11;
    access(1'b0, 1'b0, 8'h00);
    peek(1'b0, v); chk("R6 flag clear rd", 8'(v[7]), 8'd0);
    wait_ccf("R7 restart");
    peek(1'b1, v); chk("R7 overwrite", v, 8'h11);

    vin = 8'h99;
    access(1'b0, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    vin = 8'h66;
    access(1'b1, 1'b0, 8'h00);
    wait_ccf("R7 abort");
    peek(1'b1, v); chk("R7 restart code", v, 8'h66);

    access(1'b0, 1'b1, 8'h02);
    peek(1'b0, v); chk("R8 off ctl", v, 8'h02);
    vin = 8'hEE;
    access(1'b1, 1'b0, 8'h00);
    access(1'b0, 1'b0, 8'h00);
    repeat (100) @(negedge clk);
    peek(1'b0, v); chk("R8 flag stays 0", 8'(v[7]), 8'd0);
    peek(1'b1, v); chk("R8 data kept", v, 8'h66);
    chk("R8 en out", 8'(adc_en), 8'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule